// File: doc/BRIEF.md
# Lane-to-Sample Transport Remapper

This block sits behind the lane alignment and descrambling stages of a four-lane serial ADC receive link. Each cycle it takes one 128-bit word that holds four octets from every lane. It regroups those octets into 16-bit converter samples and registers them onto an output bus that runs at frame rate. The number of octets per frame is 1 or 2. Converter count M and samples per converter S only label the sample slots, and their product must equal the number of samples in one frame (2·F).

Two output modes are available through a divider parameter. In narrow mode (divider 1), one frame is emitted per accepted cycle. A frame counter picks which frame of the current lane word is shown, so the upstream stage holds a lane word for 4/F frame clocks. In wide mode (divider 4), every frame held in the lane word is placed side by side on a 128-bit bus in a single cycle.

The counter restarts whenever the link-ready input is low. Parameter sets outside the legal combinations stop elaboration with an error.

Top module: `lane_sample_remap`

## Requirements
- R1: Lane l occupies laneData[32l+31:32l]. Octet number 4l+b of the lane word sits in byte b of that lane, at laneData[32l+8b+7:32l+8b]. Octet 4l is the earliest octet on lane l.
- R2: With F=1 in narrow mode, frame k (k = 0..3) produces a 32-bit word. Bits [15:0] are {octet k, octet k+4} and bits [31:16] are {octet k+8, octet k+12}.
- R3: With F=2 in narrow mode, frame j (j = 0..1) produces a 64-bit word. Slot i (i = 0..3) sits at bits [16i+15:16i] and holds {octet 4i+2j, octet 4i+2j+1}.
- R4: Every sample takes its earlier octet as the most significant byte. Slot n holds converter m, sample s, where n = m·S + s.
- R5: In narrow mode the frame counter is 0 whenever linkReady is low. It advances by one on each accepted cycle (linkReady and inValid both high) and wraps to 0 after 4/F frames. Each accepted cycle shows the frame the counter held before that cycle.
- R6: In wide mode dataOut is 128 bits wide. Frame f of the lane word occupies bits [32F·(f+1)−1 : 32F·f], with no counter involved.
- R7: outValid is high in the cycle after an accepted cycle, and dataOut carries that cycle's samples with the same one-register latency.
- R8: After a cycle that is not accepted, outValid is low and dataOut keeps its previous value.
- R9: While reset is active, outValid is 0, dataOut is 0 and the frame counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linkReady | input | 1 | Link aligned; low clears the frame counter |
| inValid | input | 1 | laneData holds valid octets this cycle |
| laneData | input | 128 | Four lanes of four octets each |
| outValid | output | 1 | dataOut holds new samples |
| dataOut | output | 32·F (narrow) or 128 (wide) | Remapped sample slots, 16 bits each |

## Verification
The assertions check three things on every cycle. The counter clears while the link is down and steps and wraps on accepted cycles. Output valid appears exactly one cycle after acceptance, and output data holds steady when nothing is accepted. Only the bench scenarios can show that octets land in the right sample slots, that each M/S labelling reads the right slot, and that wide mode places the frames in the right order. For this, six configurations are driven side by side with an incrementing octet pattern and with random words, and results are compared against an independent model of the octet-to-slot mapping.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int LANES          = 4;
  localparam int OCTETS_PER_LANE = 4;
  localparam int LANE_W         = 8 * OCTETS_PER_LANE;
  localparam int BUS_W          = LANES * LANE_W;
  localparam int SAMPLE_W       = 16;
  localparam int SEL_W          = 2;

  typedef struct packed {
    logic             capture;
    logic [SEL_W-1:0] frameSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int OCT_PER_FRAME = 1,
  parameter int FRAME_DIV     = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkReady,
  input  logic        inValid,
  output ctrlStrobe_t ctrl
);

  localparam int FRAMES = OCTETS_PER_LANE / OCT_PER_FRAME;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(FRAMES - 1);

  logic accept;
  assign accept = linkReady && inValid;
  assign ctrl.capture = accept;

  if (FRAME_DIV == 1) begin : g_counter
    logic [SEL_W-1:0] frameCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        frameCnt <= '0;
      end else if (!linkReady) begin
        frameCnt <= '0;
      end else if (inValid) begin
        frameCnt <= (frameCnt == LAST) ? '0 : frameCnt + 1'b1;
      end
    end

    assign ctrl.frameSel = frameCnt;

    // R5: link down restarts the frame sequence
    a_r5_clear_on_link_down: assert property (@(posedge clk) disable iff (!rstN)
      !linkReady |=> frameCnt == '0);

    // R5: an accepted cycle moves to the next frame, wrapping at the last
    a_r5_step_and_wrap: assert property (@(posedge clk) disable iff (!rstN)
      accept |=> frameCnt == (($past(frameCnt) == LAST) ? '0 : $past(frameCnt) + 1'b1));

    // R5: idle cycles leave the sequence where it was
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
      (linkReady && !inValid) |=> $stable(frameCnt));
  end else begin : g_noCounter
    assign ctrl.frameSel = '0;
  end

endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int OCT_PER_FRAME = 1,
  parameter int FRAME_DIV     = 1,
  parameter int OUT_W         = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  input  logic [BUS_W-1:0] laneData,
  output logic             outValid,
  output logic [OUT_W-1:0] dataOut
);

  localparam int FRAMES        = OCTETS_PER_LANE / OCT_PER_FRAME;
  localparam int FRAME_OCTETS  = LANES * OCT_PER_FRAME;
  localparam int FRAME_W       = 8 * FRAME_OCTETS;

  // Octets of one frame are taken lane by lane; consecutive pairs form a sample,
  // the earlier octet in the upper byte.
  function automatic logic [FRAME_W-1:0] buildFrame(input logic [BUS_W-1:0] lanes,
                                                    input logic [SEL_W-1:0] idx);
    logic [FRAME_W-1:0] word;
    int lane, offs, src, dst;
    word = '0;
    for (int p = 0; p < FRAME_OCTETS; p++) begin
      lane = p / OCT_PER_FRAME;
      offs = p % OCT_PER_FRAME;
      src  = lane * OCTETS_PER_LANE + int'(idx) * OCT_PER_FRAME + offs;
      dst  = (p / 2) * SAMPLE_W + (((p % 2) == 0) ? 8 : 0);
      word[dst +: 8] = lanes[src*8 +: 8];
    end
    return word;
  endfunction

  logic [OUT_W-1:0] nextData;

  if (FRAME_DIV == 1) begin : g_narrow
    assign nextData = buildFrame(laneData, ctrl.frameSel);
  end else begin : g_wide
    logic unusedSel;
    assign unusedSel = ^ctrl.frameSel;
    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
      assign nextData[f*FRAME_W +: FRAME_W] = buildFrame(laneData, SEL_W'(f));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dataOut  <= '0;
    end else begin
      outValid <= ctrl.capture;
      if (ctrl.capture) dataOut <= nextData;
    end
  end

  // R8: nothing captured means no valid and unchanged samples
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> (!outValid && $stable(dataOut)));

  // R7: a capture strobe always yields a valid output next cycle
  a_r7_valid_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> outValid);

endmodule

// File: rtl/lane_sample_remap.sv
module lane_sample_remap
  import remap_pkg::*;
#(
  parameter int OCT_PER_FRAME = 1,
  parameter int CONV_M        = 1,
  parameter int SAMP_S        = 2,
  parameter int FRAME_DIV     = 1,
  localparam int OUT_W        = (FRAME_DIV == 4) ? BUS_W : 32 * OCT_PER_FRAME
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkReady,
  input  logic             inValid,
  input  logic [BUS_W-1:0] laneData,
  output logic             outValid,
  output logic [OUT_W-1:0] dataOut
);

  localparam bit PARAMS_OK = (OCT_PER_FRAME == 1 || OCT_PER_FRAME == 2)
                          && (CONV_M * SAMP_S == 2 * OCT_PER_FRAME)
                          && (FRAME_DIV == 1 || FRAME_DIV == 4);

  if (!PARAMS_OK) begin : g_badParams
    $error("lane_sample_remap: unsupported F/M/S/divider combination");
  end

  ctrlStrobe_t ctrl;

  remap_ctrl #(
    .OCT_PER_FRAME(OCT_PER_FRAME),
    .FRAME_DIV    (FRAME_DIV)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .linkReady(linkReady),
    .inValid  (inValid),
    .ctrl     (ctrl)
  );

  remap_datapath #(
    .OCT_PER_FRAME(OCT_PER_FRAME),
    .FRAME_DIV    (FRAME_DIV),
    .OUT_W        (OUT_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .laneData(laneData),
    .outValid(outValid),
    .dataOut (dataOut)
  );

  // R7: output valid only ever follows an accepted input cycle
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(linkReady && inValid));

endmodule

// File: tb/test_lane_sample_remap.sv
module test_lane_sample_remap;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         linkReady = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] laneData = '0;

  always #4 clk = ~clk;

  logic vA, vB, vC, vD, vE, vF;
  logic [31:0]  dA, dF;
  logic [127:0] dB, dD;
  logic [63:0]  dC, dE;

  // A: F=1 M=1 S=2 narrow
  lane_sample_remap #(.OCT_PER_FRAME(1), .CONV_M(1), .SAMP_S(2), .FRAME_DIV(1)) i_lane_sample_remap (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .inValid(inValid), .laneData(laneData),
    .outValid(vA), .dataOut(dA));
  // B: F=1 M=2 S=1 wide
  lane_sample_remap #(.OCT_PER_FRAME(1), .CONV_M(2), .SAMP_S(1), .FRAME_DIV(4)) i_lane_sample_remap_b (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .inValid(inValid), .laneData(laneData),
    .outValid(vB), .dataOut(dB));
  // C: F=2 M=1 S=4 narrow
  lane_sample_remap #(.OCT_PER_FRAME(2), .CONV_M(1), .SAMP_S(4), .FRAME_DIV(1)) i_lane_sample_remap_c (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .inValid(inValid), .laneData(laneData),
    .outValid(vC), .dataOut(dC));
  // D: F=2 M=2 S=2 wide
  lane_sample_remap #(.OCT_PER_FRAME(2), .CONV_M(2), .SAMP_S(2), .FRAME_DIV(4)) i_lane_sample_remap_d (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .inValid(inValid), .laneData(laneData),
    .outValid(vD), .dataOut(dD));
  // E: F=2 M=4 S=1 narrow
  lane_sample_remap #(.OCT_PER_FRAME(2), .CONV_M(4), .SAMP_S(1), .FRAME_DIV(1)) i_lane_sample_remap_e (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .inValid(inValid), .laneData(laneData),
    .outValid(vE), .dataOut(dE));
  // F: F=1 M=2 S=1 narrow
  lane_sample_remap #(.OCT_PER_FRAME(1), .CONV_M(2), .SAMP_S(1), .FRAME_DIV(1)) i_lane_sample_remap_f (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .inValid(inValid), .laneData(laneData),
    .outValid(vF), .dataOut(dF));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int cnt1 = 0;
  int cnt2 = 0;
  logic         eVld = 1'b0;
  logic [31:0]  eA = '0, eF = '0;
  logic [127:0] eB = '0, eD = '0;
  logic [63:0]  eC = '0, eE = '0;

  function automatic logic [7:0] octetAt(input logic [127:0] d, input int idx);
    return d[idx*8 +: 8];
  endfunction

  // index of the octet feeding position pos of frame fr, for f octets per frame
  function automatic int srcIndex(input int f, input int fr, input int pos);
    return 4 * (pos / f) + fr * f + (pos % f);
  endfunction

  function automatic logic [15:0] sampleOf(input logic [127:0] d, input int f,
                                           input int fr, input int slot);
    return {octetAt(d, srcIndex(f, fr, 2*slot)), octetAt(d, srcIndex(f, fr, 2*slot + 1))};
  endfunction

  function automatic logic [63:0] frameWord(input logic [127:0] d, input int f, input int fr);
    logic [63:0] w = '0;
    for (int s = 0; s < 2*f; s++) w[16*s +: 16] = sampleOf(d, f, fr, s);
    return w;
  endfunction

  function automatic logic [127:0] wideWord(input logic [127:0] d, input int f);
    logic [127:0] w = '0;
    for (int fr = 0; fr < 4/f; fr++)
      for (int s = 0; s < 2*f; s++)
        w[16*(fr*2*f + s) +: 16] = sampleOf(d, f, fr, s);
    return w;
  endfunction

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic ready, input logic valid, input logic [127:0] d);
    logic [63:0] tmp;
    bit acc;
    linkReady = ready;
    inValid   = valid;
    laneData  = d;
    acc = ready && valid;
    if (acc) begin
      tmp = frameWord(d, 1, cnt1); eA = tmp[31:0]; eF = tmp[31:0];
      eC = frameWord(d, 2, cnt2);  eE = eC;
      eB = wideWord(d, 1);
      eD = wideWord(d, 2);
    end
    eVld = acc;
    if (!ready) begin cnt1 = 0; cnt2 = 0; end
    else if (valid) begin cnt1 = (cnt1 + 1) % 4; cnt2 = (cnt2 + 1) % 2; end
    @(posedge clk);
    @(negedge clk);
    check(acc ? "R7 valid after accept" : "R8 valid low when idle", {5'd0, vA, vB, vC, vD, vE, vF},
          {122'd0, {6{eVld}}});
    check(acc ? "R2 F1 narrow M1S2" : "R8 hold F1 narrow", {96'd0, dA}, {96'd0, eA});
    check(acc ? "R4 F1 narrow M2S1" : "R8 hold F1 M2S1", {96'd0, dF}, {96'd0, eF});
    check(acc ? "R3 F2 narrow M1S4" : "R8 hold F2 M1S4", {64'd0, dC}, {64'd0, eC});
    check(acc ? "R4 F2 narrow M4S1" : "R8 hold F2 M4S1", {64'd0, dE}, {64'd0, eE});
    check(acc ? "R6 F1 wide" : "R8 hold F1 wide", dB, eB);
    check(acc ? "R6 F2 wide" : "R8 hold F2 wide", dD, eD);
  endtask

  function automatic logic [127:0] rampWord(input logic [7:0] base);
    logic [127:0] w;
    for (int i = 0; i < 16; i++) w[i*8 +: 8] = base + 8'(i);
    return w;
  endfunction

  initial begin
    logic [127:0] ramp;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", {122'd0, vA, vB, vC, vD, vE, vF}, 128'd0);
    check("R9 reset data", {32'd0, dA, dC}, 128'd0);
    check("R9 reset wide data", dB | dD, 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: incrementing octet pattern, octet i = 0x10 + i
    ramp = rampWord(8'h10);
    step(1'b1, 1'b1, ramp);
    check("R1 lane layout F1 frame0", {96'd0, dA}, {96'd0, 32'h181C_1014});
    check("R4 F1 M1S0/M0S0 slots", {96'd0, dF[31:16], dF[15:0]}, {96'd0, 16'h181C, 16'h1014});
    check("R1 lane layout F2 frame0", {64'd0, dC}, {64'd0, 64'h1C1D_1819_1415_1011});
    step(1'b1, 1'b1, ramp);
    check("R2 F1 frame1", {96'd0, dA}, {96'd0, 32'h191D_1115});
    check("R3 F2 frame1", {64'd0, dC}, {64'd0, 64'h1E1F_1A1B_1617_1213});
    step(1'b1, 1'b1, ramp);
    step(1'b1, 1'b1, ramp);
    check("R5 F1 wrap frame3", {96'd0, dA}, {96'd0, 32'h1B1F_1317});
    step(1'b1, 1'b1, ramp);
    check("R5 F1 back to frame0", {96'd0, dA}, {96'd0, 32'h181C_1014});
    check("R6 F1 wide frame order", dB,
          {32'h1B1F_1317, 32'h1A1E_1216, 32'h191D_1115, 32'h181C_1014});
    check("R6 F2 wide frame order", dD,
          {64'h1E1F_1A1B_1617_1213, 64'h1C1D_1819_1415_1011});
    // idle and link drop
    step(1'b1, 1'b0, rampWord(8'h80));
    step(1'b0, 1'b1, rampWord(8'h90));
    step(1'b1, 1'b1, ramp);
    check("R5 restart after link drop", {96'd0, dA}, {96'd0, 32'h181C_1014});

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [127:0] d;
      d = {$urandom, $urandom, $urandom, $urandom};
      if (n % 97 == 0) d = rampWord(8'($urandom));
      step(($urandom % 16) != 0, ($urandom % 4) != 0, d);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule